// File: doc/BRIEF.md
# Serial Byte Shifter with Acknowledge Slot

This block is the serial datapath of a two-wire bus interface. A processor writes a byte into its data register in parallel and reads it back the same way. Timing logic outside the block supplies two one-cycle strobes. The sample strobe marks the rising edge of the serial clock, and the drive strobe marks the falling edge. Each sample strobe shifts the data register left by one place, most significant bit first, and takes the level seen on the data line into bit zero. The ninth sample strobe of a byte does not touch the data register: it stores the sampled level in an acknowledge flag, and a one-cycle completion pulse follows.

The block does not drive the data line straight from the shift register. A one-bit output buffer stands between them. On each drive strobe in the data phase, the buffer copies the current top bit of the data register. From the acknowledge slot onward, the buffer is set to one. The line is open-drain, so a zero in the buffer pulls the line low and a one releases it, which leaves the receiver free to acknowledge.

An internal bit counter goes back to zero when the processor loads a byte or when a new transfer is announced. The data register holds a whole byte only between transfers. While shifting is under way it holds a mix of old and new bits.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, the data register reads 0x00, the acknowledge flag is 0, the line is released (sdaDriveLow = 0), and byteDone is 0.
- R2: When cpuLoad is high at an edge, cpuWrData is in cpuRdData after that edge, and the bit counter returns to 0. Any sample strobe in the same cycle has no effect.
- R3: A sample strobe while the counter is below 8 moves cpuRdData to {cpuRdData[6:0], sdaIn} and increments the counter.
- R4: A sample strobe while the counter is 8 copies sdaIn into ackFlag and leaves cpuRdData unchanged.
- R5: byteDone is high for exactly one cycle, in the cycle right after the edge that captured the acknowledge bit.
- R6: A drive strobe while the counter is below 8 loads the output buffer with bit 7 of the data register as it stood before that edge.
- R7: A drive strobe while the counter is 8 or more sets the output buffer to 1, which releases the line during the acknowledge slot.
- R8: The line is open-drain: sdaDriveLow is 1 exactly when the output buffer holds 0.
- R9: After the acknowledge bit, more sample strobes change neither cpuRdData nor ackFlag, and they raise no byteDone, until the counter is reset.
- R10: xferStart returns the counter to 0 and does not change the data register. Any sample strobe in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuLoad | input | 1 | Parallel write strobe for the data register |
| cpuWrData | input | 8 | Byte to write |
| cpuRdData | output | 8 | Current data register contents |
| xferStart | input | 1 | Announces a new transfer and clears the bit counter |
| shiftIn | input | 1 | Sample strobe at the rising serial clock edge |
| shiftOut | input | 1 | Drive strobe at the falling serial clock edge |
| sdaIn | input | 1 | Sampled data line level |
| sdaDriveLow | output | 1 | Pulls the data line low when 1 |
| ackFlag | output | 1 | Acknowledge bit captured in the ninth slot |
| byteDone | output | 1 | One-cycle pulse after the acknowledge capture |

## Verification
Some rules are checked by assertions on every cycle. The counter never goes past nine. A load always leaves the counter at zero. The completion pulse never lasts two cycles. The acknowledge capture leaves the data bits alone. A release strobe always leaves the buffer at one. Other rules depend on how the block's parts work together, and only the bench scenarios can show them. These include the exact order of bits on the line for a whole byte, the buffer reading the pre-edge top bit when sample and drive strobes come in the same cycle, and whether load and start take priority over shifting. The bench runs random strobe mixes against a step model to cover these.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef struct packed {
    logic loadData;
    logic shiftData;
    logic shiftAck;
    logic outData;
    logic outRelease;
  } shiftStrobes_t;
endpackage

// File: rtl/shifter_ctrl.sv
module shifter_ctrl
  import shifter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuLoad,
  input  logic          xferStart,
  input  logic          shiftIn,
  input  logic          shiftOut,
  output shiftStrobes_t strb,
  output logic          byteDone
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] FINISHED = CNT_W'(DATA_W + 1);

  logic [CNT_W-1:0] bitCnt;
  logic inData;
  logic inAck;
  logic restart;

  assign inData  = bitCnt < ACK_SLOT;
  assign inAck   = bitCnt == ACK_SLOT;
  assign restart = cpuLoad | xferStart;

  always_comb begin
    strb.loadData   = cpuLoad;
    strb.shiftData  = shiftIn & ~restart & inData;
    strb.shiftAck   = shiftIn & ~restart & inAck;
    strb.outData    = shiftOut & inData;
    strb.outRelease = shiftOut & ~inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= strb.shiftAck;
      if (restart)             bitCnt <= '0;
      else if (strb.shiftData) bitCnt <= bitCnt + 1'b1;
      else if (strb.shiftAck)  bitCnt <= FINISHED;
    end
  end

  // R9: the counter stops at the finished state
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FINISHED);
  // R2: a load always clears the counter
  p_load_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuLoad |=> bitCnt == '0);
  // R5: completion pulse lasts one cycle
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);
  // R10: start clears the counter
  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> bitCnt == '0);
endmodule

// File: rtl/shifter_datapath.sv
module shifter_datapath
  import shifter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobes_t     strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] dataReg,
  output logic              ackBit,
  output logic              outBuf
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      ackBit  <= 1'b0;
      outBuf  <= 1'b1;
    end else begin
      if (strb.loadData)       dataReg <= wrData;
      else if (strb.shiftData) dataReg <= {dataReg[DATA_W-2:0], sdaIn};
      if (strb.shiftAck)       ackBit <= sdaIn;
      if (strb.outData)        outBuf <= dataReg[DATA_W-1];
      else if (strb.outRelease) outBuf <= 1'b1;
    end
  end

  // R4: acknowledge capture leaves data bits untouched
  p_ack_keeps_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftAck && !strb.loadData |=> $stable(dataReg));
  // R7: release strobe always leaves the line released
  p_release_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.outRelease |=> outBuf);
  // R3: data shifts never disturb the acknowledge flag
  p_shift_keeps_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftData |=> $stable(ackBit));
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import shifter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuLoad,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              xferStart,
  input  logic              shiftIn,
  input  logic              shiftOut,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic              ackFlag,
  output logic              byteDone
);
  shiftStrobes_t strb;
  logic outBuf;

  shifter_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuLoad(cpuLoad), .xferStart(xferStart),
    .shiftIn(shiftIn), .shiftOut(shiftOut), .strb(strb), .byteDone(byteDone)
  );

  shifter_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(cpuWrData), .sdaIn(sdaIn),
    .dataReg(cpuRdData), .ackBit(ackFlag), .outBuf(outBuf)
  );

  assign sdaDriveLow = ~outBuf;

  // R5: completion only follows the acknowledge capture
  p_done_after_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> $past(shiftIn) && !$past(cpuLoad) && !$past(xferStart));
endmodule

// File: tb/i2c_byte_shifter_tb.sv
`timescale 1ns/1ps
module i2c_byte_shifter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuLoad = 1'b0, xferStart = 1'b0, shiftIn = 1'b0, shiftOut = 1'b0, sdaIn = 1'b1;
  logic [7:0] cpuWrData = 8'h00;
  logic [7:0] cpuRdData;
  logic sdaDriveLow, ackFlag, byteDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] mData = 8'h00;
  logic mAck = 1'b0, mOut = 1'b1, mDone = 1'b0;
  int mCnt = 0;

  always #2.5 clk = ~clk;

  i2c_byte_shifter u_dut (
    .clk(clk), .rstN(rstN), .cpuLoad(cpuLoad), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .xferStart(xferStart), .shiftIn(shiftIn),
    .shiftOut(shiftOut), .sdaIn(sdaIn), .sdaDriveLow(sdaDriveLow),
    .ackFlag(ackFlag), .byteDone(byteDone)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic nextOut(input logic so, input int cnt, input logic [7:0] d, input logic cur);
    if (!so) return cur;
    return (cnt < 8) ? d[7] : 1'b1;
  endfunction

  // one cycle: drive at negedge, model the edge, compare at the next negedge
  task automatic step(input logic ld, input logic [7:0] wd, input logic st,
                      input logic si, input logic so, input logic bitIn);
    @(negedge clk);
    cpuLoad = ld; cpuWrData = wd; xferStart = st;
    shiftIn = si; shiftOut = so; sdaIn = bitIn;
    mOut  = nextOut(so, mCnt, mData, mOut);
    mDone = 1'b0;
    if (ld) begin mData = wd; mCnt = 0; end
    else if (st) mCnt = 0;
    else if (si) begin
      if (mCnt < 8) begin mData = {mData[6:0], bitIn}; mCnt++; end
      else if (mCnt == 8) begin mAck = bitIn; mCnt = 9; mDone = 1'b1; end
    end
    @(negedge clk);
    cpuLoad = 1'b0; xferStart = 1'b0; shiftIn = 1'b0; shiftOut = 1'b0;
    chk("R3 data", cpuRdData, mData);
    chk("R4 ack", {7'd0, ackFlag}, {7'd0, mAck});
    chk("R8 sda", {7'd0, sdaDriveLow}, {7'd0, ~mOut});
    chk("R5 done", {7'd0, byteDone}, {7'd0, mDone});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen;
    logic [7:0] keep;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 data", cpuRdData, 8'h00);
    chk("R1 ack", {7'd0, ackFlag}, 8'h00);
    chk("R1 sda", {7'd0, sdaDriveLow}, 8'h00);
    chk("R1 done", {7'd0, byteDone}, 8'h00);
    rstN = 1'b1;

    // R2 load with a simultaneous sample strobe: the shift is dropped
    step(1, 8'hA5, 0, 1, 0, 0);
    chk("R2 load", cpuRdData, 8'hA5);

    // R6 R7 transmit a whole byte, watching the line bit by bit
    seen = 8'h00;
    for (int b = 0; b < 8; b++) begin
      step(0, 8'h00, 0, 0, 1, 0);
      seen = {seen[6:0], ~sdaDriveLow};
      step(0, 8'h00, 0, 1, 0, ~sdaDriveLow);
    end
    chk("R6 serial order", seen, 8'hA5);
    step(0, 8'h00, 0, 0, 1, 0);
    chk("R7 ack slot released", {7'd0, sdaDriveLow}, 8'h00);
    step(0, 8'h00, 0, 1, 0, 0);
    chk("R5 done after ninth", {7'd0, byteDone}, 8'h01);
    chk("R4 ack low", {7'd0, ackFlag}, 8'h00);

    // R9 extra strobes ignored
    keep = cpuRdData;
    step(0, 8'h00, 0, 1, 0, 1);
    step(0, 8'h00, 0, 1, 1, 1);
    chk("R9 data held", cpuRdData, keep);
    chk("R9 ack held", {7'd0, ackFlag}, 8'h00);
    chk("R9 no done", {7'd0, byteDone}, 8'h00);

    // R10 start with a sample strobe: counter cleared, data kept, shift dropped
    step(0, 8'h00, 1, 1, 0, 1);
    chk("R10 data kept", cpuRdData, keep);
    for (int b = 0; b < 8; b++) step(0, 8'h00, 0, 1, 0, b[0]);
    chk("R10 receive after restart", cpuRdData, 8'h55);
    step(0, 8'h00, 0, 1, 0, 1);
    chk("R4 ack high", {7'd0, ackFlag}, 8'h01);

    // random strobe mixes against the step model
    for (int i = 0; i < 3000; i++) begin
      logic ld, st;
      ld = ($urandom_range(0, 19) == 0);
      st = ($urandom_range(0, 29) == 0);
      step(ld, 8'($urandom), st, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule